// File: doc/BRIEF.md
# Interrupt Redirection Register Window

This block is the software-visible front end of an interrupt redirection controller. Software reaches it through a small memory-mapped region. A byte-wide select register names an internal register, and a 32-bit data window reads or writes the register it names. A separate end-of-interrupt register passes a vector on to the delivery logic. Only the low eight address bits are decoded, so the region repeats every 256 bytes inside its 4 KB aperture.

Through the window, software sees three registers: an identification register, a version register and an arbitration register. It also sees the redirection table, one 64-bit entry per input pin, split into a low and a high 32-bit half. Two bits of every entry, the delivery status and the remote-request flag, are owned by the delivery engine. The delivery engine updates them through a status port. Bus writes cannot change these two bits. After each entry write, the block does two things. It clears the remote-request flag if the entry is now edge-triggered. It then reports the stored entry on an update port and raises a one-cycle service request, so that the delivery engine runs a new pass. The block does not deliver interrupts itself.

Entry bit layout: vector [7:0], delivery mode [10:8], destination mode [11], delivery status [12], polarity [13], remote request [14], trigger [15] (1 = level, 0 = edge), mask [16], destination [63:56].

Top module: `irq_window_regs`

## Requirements
- R1: After reset, the select register reads 0x00, the identification is 0, and every entry holds 0x00000000_00010000, which means masked and edge-triggered.
- R2: Only address bits [7:0] are decoded. The select register is at offset 0x00, the window at 0x10 and the end-of-interrupt register at 0x40. Higher address bits do not change the result.
- R3: The select register accepts writes of any access width and reads back its full 8-bit value at any access width.
- R4: A window access whose width is not 32 bits has no effect, and a window read of that kind returns 0.
- R5: A 32-bit write to select 0x00 stores write-data bits [27:24] as the identification. Selects 0x00 and 0x02 both read the identification in bits [27:24], with all other bits 0. Writes to selects 0x01 and 0x02 change nothing.
- R6: Select 0x01 reads VERSION in bits [7:0] and (NUM_PINS-1) in bits [23:16], with all other bits 0.
- R7: Entry n is at select 0x10+2n for its low half and 0x11+2n for its high half. Selects that are not mapped, including those past the table, read 0. Writes to them produce no entry update and no service request.
- R8: Entry bits 12 and 14 keep their previous values on every bus write. Only the status port (stat_we, stat_idx, stat_dlv, stat_rirr) sets them.
- R9: If an entry write leaves bit 15 at 0 (edge), bit 14 of that entry is cleared.
- R10: Every 32-bit write to an entry half causes the following. One cycle after the request, svc_req and tbl_upd_valid are high for exactly one cycle, tbl_upd_idx carries n, and tbl_upd_entry carries the stored 64-bit entry.
- R11: When VERSION is 0x20, a 32-bit write to offset 0x40 makes eoi_valid high for one cycle, one cycle later, with eoi_vector equal to write-data [7:0]. Narrow writes to 0x40 are ignored. With any other VERSION, all writes to 0x40 are ignored.
- R12: A read returns its data on rd_data one cycle after the request, with rd_valid high for that cycle. Offsets that are not mapped read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size32 | input | 1 | Access is 32 bits wide |
| req_addr | input | ADDR_W | Byte address within the region |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| stat_we | input | 1 | Delivery engine updates status bits |
| stat_idx | input | IDX_W | Entry addressed by the status update |
| stat_dlv | input | 1 | New delivery status bit |
| stat_rirr | input | 1 | New remote-request bit |
| tbl_upd_valid | output | 1 | An entry was written by the bus |
| tbl_upd_idx | output | IDX_W | Index of the written entry |
| tbl_upd_entry | output | 64 | Stored value of the written entry |
| svc_req | output | 1 | Service pass request pulse |
| eoi_valid | output | 1 | End-of-interrupt pulse |
| eoi_vector | output | 8 | End-of-interrupt vector |

## Verification
The bench builds two copies of the block with NUM_PINS = 4. The main copy uses VERSION = 0x20, and the second uses VERSION = 0x11 and shares the same bus stimulus. The small table puts the last entry (select 0x17) and the first select past the table (0x18) within a few accesses, so both edges of the index range are exercised. The second copy shows that the end-of-interrupt register and the version field both depend on the parameter.

// File: rtl/irqwin_pkg.sv
package irqwin_pkg;

    localparam logic [7:0] OFFS_SELECT = 8'h00;
    localparam logic [7:0] OFFS_WINDOW = 8'h10;
    localparam logic [7:0] OFFS_EOI    = 8'h40;

    localparam logic [7:0] SEL_IDENT   = 8'h00;
    localparam logic [7:0] SEL_VERSION = 8'h01;
    localparam logic [7:0] SEL_ARBIT   = 8'h02;
    localparam logic [7:0] SEL_TABLE   = 8'h10;

    localparam int unsigned IDENT_W   = 4;
    localparam int unsigned IDENT_LSB = 24;
    localparam int unsigned MAXENT_LSB = 16;

    localparam logic [63:0] RO_BITS   = 64'h0000_0000_0000_5000;
    localparam logic [63:0] ENTRY_RST = 64'h0000_0000_0001_0000;

    typedef enum logic [1:0] {
        OK_SELECT,
        OK_WINDOW,
        OK_EOI,
        OK_NONE
    } off_kind_e;

    typedef enum logic [2:0] {
        WR_IDENT,
        WR_VERSION,
        WR_ARBIT,
        WR_ENTRY,
        WR_NONE
    } win_reg_e;

    typedef struct packed {
        win_reg_e   kind;
        logic       hi;
        logic [7:0] slot;
    } win_dec_t;

    typedef struct packed {
        logic [7:0]  dest;
        logic [38:0] rsvd;
        logic        mask;
        logic        trig;
        logic        rirr;
        logic        pol;
        logic        dlv;
        logic        dmode;
        logic [2:0]  dlvmode;
        logic [7:0]  vec;
    } rte_t;

    function automatic off_kind_e classify_offset(input logic [7:0] off);
        case (off)
            OFFS_SELECT: return OK_SELECT;
            OFFS_WINDOW: return OK_WINDOW;
            OFFS_EOI:    return OK_EOI;
            default:     return OK_NONE;
        endcase
    endfunction

    function automatic win_dec_t decode_select(input logic [7:0] sel,
                                               input int unsigned pins);
        win_dec_t d;
        logic [7:0] rel;
        rel    = sel - SEL_TABLE;
        d.kind = WR_NONE;
        d.hi   = sel[0];
        d.slot = {1'b0, rel[7:1]};
        if (sel == SEL_IDENT)        d.kind = WR_IDENT;
        else if (sel == SEL_VERSION) d.kind = WR_VERSION;
        else if (sel == SEL_ARBIT)   d.kind = WR_ARBIT;
        else if (sel >= SEL_TABLE && {24'd0, sel} < 32'(16 + 2 * pins))
            d.kind = WR_ENTRY;
        return d;
    endfunction

endpackage

// File: rtl/win_decode.sv
module win_decode
    import irqwin_pkg::*;
#(
    parameter int unsigned NUM_PINS = 24
) (
    input  logic [7:0] off,
    input  logic [7:0] sel,
    output off_kind_e  okind,
    output win_dec_t   wdec
);
    always_comb begin
        okind = classify_offset(off);
        wdec  = decode_select(sel, NUM_PINS);
    end
endmodule

// File: rtl/rte_store.sv
module rte_store
    import irqwin_pkg::*;
#(
    parameter int unsigned NUM_PINS = 24,
    parameter int unsigned IDX_W    = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_we,
    input  logic [IDX_W-1:0] bus_idx,
    input  logic [63:0]      bus_val,
    input  logic             st_we,
    input  logic [IDX_W-1:0] st_idx,
    input  logic             st_dlv,
    input  logic             st_rirr,
    input  logic [IDX_W-1:0] rd_a_idx,
    output rte_t             rd_a_val,
    input  logic [IDX_W-1:0] rd_b_idx,
    output rte_t             rd_b_val
);
    rte_t ent_w [NUM_PINS];

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_ent
        rte_t q;
        rte_t nxt;

        always_comb begin
            nxt = q;
            if (st_we && st_idx == IDX_W'(g)) begin
                nxt.dlv  = st_dlv;
                nxt.rirr = st_rirr;
            end
            if (bus_we && bus_idx == IDX_W'(g)) begin
                nxt = rte_t'((bus_val & ~RO_BITS) | (64'(nxt) & RO_BITS));
                if (!nxt.trig) nxt.rirr = 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) q <= rte_t'(ENTRY_RST);
            else     q <= nxt;
        end

        assign ent_w[g] = q;
    end

    always_comb begin
        rd_a_val = rte_t'(ENTRY_RST);
        rd_b_val = rte_t'(ENTRY_RST);
        if (32'(rd_a_idx) < NUM_PINS) rd_a_val = ent_w[rd_a_idx];
        if (32'(rd_b_idx) < NUM_PINS) rd_b_val = ent_w[rd_b_idx];
    end
endmodule

// File: rtl/irq_window_regs.sv
module irq_window_regs
    import irqwin_pkg::*;
#(
    parameter int unsigned NUM_PINS = 24,
    parameter logic [7:0]  VERSION  = 8'h20,
    parameter int unsigned ADDR_W   = 12,
    localparam int unsigned IDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_size32,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    input  logic              stat_we,
    input  logic [IDX_W-1:0]  stat_idx,
    input  logic              stat_dlv,
    input  logic              stat_rirr,
    output logic              tbl_upd_valid,
    output logic [IDX_W-1:0]  tbl_upd_idx,
    output logic [63:0]       tbl_upd_entry,
    output logic              svc_req,
    output logic              eoi_valid,
    output logic [7:0]        eoi_vector
);
    localparam bit EOI_EN = (VERSION == 8'h20);
    localparam logic [31:0] VER_WORD =
        {8'h00, 8'(NUM_PINS - 1), 8'h00, VERSION};

    logic [7:0]         sel_q;
    logic [IDENT_W-1:0] ident_q;
    off_kind_e          okind;
    win_dec_t           wdec;
    rte_t               cur_ent;
    rte_t               upd_ent;
    logic [63:0]        bus_val;
    logic [31:0]        rd_word;
    logic [31:0]        ident_word;
    logic               wr_go, rd_go, win_ok, ent_wr, eoi_hit;
    logic [IDX_W-1:0]   ent_idx;

    win_decode #(.NUM_PINS(NUM_PINS)) u_dec (
        .off   (req_addr[7:0]),
        .sel   (sel_q),
        .okind (okind),
        .wdec  (wdec)
    );

    assign wr_go   = req_valid & req_write;
    assign rd_go   = req_valid & ~req_write;
    assign win_ok  = (okind == OK_WINDOW) & req_size32;
    assign ent_wr  = wr_go & win_ok & (wdec.kind == WR_ENTRY);
    assign ent_idx = wdec.slot[IDX_W-1:0];
    assign eoi_hit = EOI_EN & wr_go & req_size32 & (okind == OK_EOI);

    assign bus_val = wdec.hi ? {req_wdata, cur_ent[31:0]}
                             : {cur_ent[63:32], req_wdata};

    rte_store #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_tbl (
        .clk      (clk),
        .rst      (rst),
        .bus_we   (ent_wr),
        .bus_idx  (ent_idx),
        .bus_val  (bus_val),
        .st_we    (stat_we),
        .st_idx   (stat_idx),
        .st_dlv   (stat_dlv),
        .st_rirr  (stat_rirr),
        .rd_a_idx (ent_idx),
        .rd_a_val (cur_ent),
        .rd_b_idx (tbl_upd_idx),
        .rd_b_val (upd_ent)
    );

    assign tbl_upd_entry = upd_ent;
    assign ident_word    = 32'(ident_q) << IDENT_LSB;

    always_comb begin
        rd_word = '0;
        case (okind)
            OK_SELECT: rd_word = {24'd0, sel_q};
            OK_WINDOW: begin
                if (req_size32) begin
                    case (wdec.kind)
                        WR_IDENT, WR_ARBIT: rd_word = ident_word;
                        WR_VERSION:         rd_word = VER_WORD;
                        WR_ENTRY:           rd_word = wdec.hi ? cur_ent[63:32]
                                                              : cur_ent[31:0];
                        default:            rd_word = '0;
                    endcase
                end
            end
            default: rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q         <= '0;
            ident_q       <= '0;
            rd_valid      <= 1'b0;
            rd_data       <= '0;
            tbl_upd_valid <= 1'b0;
            tbl_upd_idx   <= '0;
            svc_req       <= 1'b0;
            eoi_valid     <= 1'b0;
            eoi_vector    <= '0;
        end else begin
            rd_valid      <= rd_go;
            if (rd_go) rd_data <= rd_word;
            if (wr_go && okind == OK_SELECT) sel_q <= req_wdata[7:0];
            if (wr_go && win_ok && wdec.kind == WR_IDENT)
                ident_q <= req_wdata[IDENT_LSB +: IDENT_W];
            tbl_upd_valid <= ent_wr;
            svc_req       <= ent_wr;
            if (ent_wr) tbl_upd_idx <= ent_idx;
            eoi_valid     <= eoi_hit;
            if (eoi_hit) eoi_vector <= req_wdata[7:0];
        end
    end
endmodule

// File: rtl/irq_window_regs_chk.sv
module irq_window_regs_chk #(
    parameter int unsigned NUM_PINS = 24,
    parameter logic [7:0]  VERSION  = 8'h20,
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned IDX_W    = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic              req_size32,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rd_valid,
    input logic [31:0]       rd_data,
    input logic              tbl_upd_valid,
    input logic [IDX_W-1:0]  tbl_upd_idx,
    input logic [63:0]       tbl_upd_entry,
    input logic              svc_req,
    input logic              eoi_valid
);
    AST_SVC_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        svc_req |-> $past(req_valid && req_write && req_size32 && req_addr[7:0] == 8'h10)); // R10

    AST_UPD_IN_TABLE: assert property (@(posedge clk) disable iff (rst)
        tbl_upd_valid |-> (32'(tbl_upd_idx) < NUM_PINS)); // R7

    AST_EDGE_CLEARS_RIRR: assert property (@(posedge clk) disable iff (rst)
        (tbl_upd_valid && !tbl_upd_entry[15]) |-> !tbl_upd_entry[14]); // R9

    AST_EOI_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        eoi_valid |-> $past(req_valid && req_write && req_size32 && req_addr[7:0] == 8'h40)); // R11

    AST_RD_FROM_READ: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(req_valid && !req_write)); // R12

    AST_NARROW_WIN_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && $past(req_addr[7:0] == 8'h10 && !req_size32)) |-> rd_data == 32'd0); // R4
endmodule

bind irq_window_regs irq_window_regs_chk #(
    .NUM_PINS(NUM_PINS), .VERSION(VERSION), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_size32    (req_size32),
    .req_addr      (req_addr),
    .rd_valid      (rd_valid),
    .rd_data       (rd_data),
    .tbl_upd_valid (tbl_upd_valid),
    .tbl_upd_idx   (tbl_upd_idx),
    .tbl_upd_entry (tbl_upd_entry),
    .svc_req       (svc_req),
    .eoi_valid     (eoi_valid)
);

// File: tb/irq_window_regs_tb_top.sv
module irq_window_regs_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PINS = 4;
    localparam int IW = 2;

    logic clk = 0, rst = 1;
    logic req_valid = 0, req_write = 0, req_size32 = 0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic stat_we = 0, stat_dlv = 0, stat_rirr = 0;
    logic [IW-1:0] stat_idx = '0;

    logic rd_valid, svc_req, eoi_valid, tbl_upd_valid;
    logic [31:0] rd_data;
    logic [IW-1:0] tbl_upd_idx;
    logic [63:0] tbl_upd_entry;
    logic [7:0] eoi_vector;

    logic v_rd_valid, v_svc, v_eoi, v_upd;
    logic [31:0] v_rd_data;
    logic [IW-1:0] v_upd_idx;
    logic [63:0] v_upd_entry;
    logic [7:0] v_eoi_vec;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [31:0] exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_window_regs #(.NUM_PINS(PINS), .VERSION(8'h20)) dut_i (
        .clk, .rst, .req_valid, .req_write, .req_size32, .req_addr, .req_wdata,
        .rd_valid, .rd_data, .stat_we, .stat_idx, .stat_dlv, .stat_rirr,
        .tbl_upd_valid, .tbl_upd_idx, .tbl_upd_entry, .svc_req, .eoi_valid, .eoi_vector);

    irq_window_regs #(.NUM_PINS(PINS), .VERSION(8'h11)) dut_v11_i (
        .clk, .rst, .req_valid, .req_write, .req_size32, .req_addr, .req_wdata,
        .rd_valid(v_rd_valid), .rd_data(v_rd_data), .stat_we, .stat_idx, .stat_dlv,
        .stat_rirr, .tbl_upd_valid(v_upd), .tbl_upd_idx(v_upd_idx),
        .tbl_upd_entry(v_upd_entry), .svc_req(v_svc), .eoi_valid(v_eoi),
        .eoi_vector(v_eoi_vec));

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: one bus access; reads push their expected word to the scoreboard.
    task automatic acc(input logic wr, input logic [11:0] a, input logic s32,
                       input logic [31:0] d, input logic [31:0] exp, input string tag);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_size32 = s32; req_wdata = d;
        if (!wr) begin
            exp_q.push_back(exp);
            tag_q.push_back(tag);
        end
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic wr32(input logic [11:0] a, input logic [31:0] d);
        acc(1'b1, a, 1'b1, d, 32'd0, "");
    endtask

    task automatic rd32(input logic [11:0] a, input logic [31:0] exp, input string tag);
        acc(1'b0, a, 1'b1, 32'd0, exp, tag);
    endtask

    task automatic status(input logic [IW-1:0] i, input logic dl, input logic rr);
        @(negedge clk);
        stat_we = 1; stat_idx = i; stat_dlv = dl; stat_rirr = rr;
        @(negedge clk);
        stat_we = 0;
    endtask

    // Monitor: compares every read response with the scoreboard head.
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R12 unexpected read actual=%h expected=none", rd_data);
            end else begin
                check(tag_q.pop_front(), {32'd0, rd_data}, {32'd0, exp_q.pop_front()});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        rd32(12'h000, 32'h0000_0000, "R1 select after reset");
        rd32(12'h010, 32'h0000_0000, "R1 ident after reset");
        wr32(12'h000, 32'h0000_0010);
        rd32(12'h010, 32'h0001_0000, "R1 entry0 low after reset");
        check("R1 no service on select write", {63'd0, svc_req}, 64'd0);
        // R3 select any width
        acc(1'b1, 12'h000, 1'b0, 32'h0000_00A5, 32'd0, "");
        acc(1'b0, 12'h000, 1'b0, 32'd0, 32'h0000_00A5, "R3 narrow select readback");
        // R6 version
        wr32(12'h000, 32'h1);
        rd32(12'h010, 32'h0003_0020, "R6 version 0x20");
        check("R6 version 0x11 instance", {32'd0, v_rd_data}, {32'd0, 32'h0003_0011});
        wr32(12'h010, 32'h0);
        rd32(12'h010, 32'h0003_0020, "R5 version write ignored");
        // R5 ident / arbitration
        wr32(12'h000, 32'h0);
        wr32(12'h010, 32'hFFFF_FFFF);
        rd32(12'h010, 32'h0F00_0000, "R5 ident readback");
        wr32(12'h000, 32'h2);
        rd32(12'h010, 32'h0F00_0000, "R5 arbitration mirrors ident");
        wr32(12'h010, 32'h0);
        rd32(12'h010, 32'h0F00_0000, "R5 arbitration write ignored");
        // R4 narrow window
        wr32(12'h000, 32'h12);
        acc(1'b1, 12'h010, 1'b0, 32'h0000_1234, 32'd0, "");
        check("R4 narrow write no service", {63'd0, svc_req}, 64'd0);
        acc(1'b0, 12'h010, 1'b0, 32'd0, 32'h0, "R4 narrow read zero");
        rd32(12'h010, 32'h0001_0000, "R4 entry1 unchanged");
        // R7 / R10 entry halves
        wr32(12'h000, 32'h13);
        wr32(12'h010, 32'hAB00_0000);
        check("R10 service pulse", {63'd0, svc_req}, 64'd1);
        check("R10 update index", {62'd0, tbl_upd_idx}, 64'd1);
        check("R10 update entry", tbl_upd_entry, 64'hAB00_0000_0001_0000);
        @(negedge clk);
        check("R10 service one cycle", {63'd0, svc_req}, 64'd0);
        rd32(12'h010, 32'hAB00_0000, "R7 entry1 high half");
        wr32(12'h000, 32'h12);
        wr32(12'h010, 32'h0000_A031);
        check("R10 update entry low", tbl_upd_entry, 64'hAB00_0000_0000_A031);
        rd32(12'h010, 32'h0000_A031, "R7 entry1 low half");
        // R8 read-only bits
        status(2'd1, 1'b1, 1'b1);
        rd32(12'h010, 32'h0000_F031, "R8 status bits set by port");
        wr32(12'h010, 32'h0000_A032);
        rd32(12'h010, 32'h0000_F032, "R8 level write keeps bits 12 14");
        wr32(12'h000, 32'h14);
        wr32(12'h010, 32'h0000_D000);
        rd32(12'h010, 32'h0000_8000, "R8 bus cannot set bits 12 14");
        // R9 edge clears remote request
        wr32(12'h000, 32'h12);
        wr32(12'h010, 32'h0000_0032);
        check("R9 update entry edge", tbl_upd_entry, 64'hAB00_0000_0000_1032);
        rd32(12'h010, 32'h0000_1032, "R9 remote request cleared");
        // R7 table bounds
        wr32(12'h000, 32'h17);
        rd32(12'h010, 32'h0000_0000, "R7 last entry high half");
        wr32(12'h000, 32'h18);
        wr32(12'h010, 32'hFFFF_FFFF);
        check("R7 out-of-range write no service", {63'd0, svc_req}, 64'd0);
        rd32(12'h010, 32'h0, "R7 out-of-range read zero");
        wr32(12'h000, 32'h0F);
        rd32(12'h010, 32'h0, "R7 unmapped select zero");
        // R11 end of interrupt
        wr32(12'h040, 32'h0000_01A5);
        check("R11 eoi pulse", {63'd0, eoi_valid}, 64'd1);
        check("R11 eoi vector", {56'd0, eoi_vector}, 64'hA5);
        check("R11 version 0x11 ignores eoi", {63'd0, v_eoi}, 64'd0);
        acc(1'b1, 12'h040, 1'b0, 32'h0000_0033, 32'd0, "");
        check("R11 narrow eoi ignored", {63'd0, eoi_valid}, 64'd0);
        // R12 unmapped offsets
        rd32(12'h020, 32'h0, "R12 unmapped offset read");
        wr32(12'h020, 32'h55);
        rd32(12'h000, 32'h0F, "R12 unmapped write no effect");
        // R2 upper address bits ignored
        wr32(12'h700, 32'h12);
        rd32(12'hF10, 32'h0000_1032, "R2 aliased window read");
        rd32(12'h300, 32'h12, "R2 aliased select read");
        repeat (3) @(negedge clk);
        check("R12 all reads answered", 64'(exp_q.size()), 64'd0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule